// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 4 KB page translation when the faster block-translation path misses. A request carries the effective address, the segment register that address selects, the page-table base/size register, the privilege state and a write flag. The walker hashes the virtual segment ID with the page index to locate a 64-byte group of eight entries in memory. It reads the entries one word at a time through a 32-bit valid/ready memory port.

Each entry's first word is compared with a tag word built from the request. On the first exact match the second word gives the physical page and a two-bit protection field. The protection field is widened by the segment's key for the current privilege. If the access earns them, the referenced and changed flags in that second word are set with single-byte writes.

When the primary group holds no match, the walker searches the secondary group, which is addressed by the complemented hash. It then reports one of three results: hit, not found or protection fault.

Top module: `hpt_walker`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle and is low from the cycle after acceptance until the result. The result is shown for exactly one cycle with `done_valid` high.
- R2: The primary group address is formed as follows. The hash is ((seg[27:0] XOR ea[27:12]) << 6), truncated to 32 bits. It is masked with ({base[8:0], 16'hFFC0}). The group address is base[31:16] in the upper half, ORed with the masked hash. Entry k occupies the tag word at group+8k and the data word at group+8k+4.
- R3: The secondary group address uses the bitwise complement of the unmasked hash, with the same mask and base. It is searched only when none of the eight primary tag words matches.
- R4: Entries are visited in order 0 to 7. For each entry the tag word is read first. The data word of an entry is read only when its tag word equals {1'b1, seg[23:0], secondary, ea[27:22]}. The first matching entry ends the search.
- R5: On a match, `done_pa` is the data word with bits [11:0] replaced by ea[11:0].
- R6: The 3-bit protection code is {key, data[1:0]}. The key is seg[29] when `req_user` is 1 and seg[30] when `req_user` is 0.
- R7: Codes 0, 1, 2 and 6 grant read and write. Codes 3, 5 and 7 grant read only. Code 4 grants nothing. The grants appear on `done_rd` and `done_wr`, which are 0 when nothing is found.
- R8: If the match is readable and data bit 8 (referenced) is clear, the walker writes the data word address with `mem_be`=4'b0010 and `mem_wdata` = data | 0x100. Byte enable bit k covers data bits [8k+7:8k].
- R9: If the request is a write, the match grants write and data bit 7 (changed) is clear, the walker writes with `mem_be`=4'b0001 and `mem_wdata` equal to the data word with 0x80 set. This value also includes 0x100 if R8 set it. This write comes after the R8 write.
- R10: `done_code` is 2'b01 for hit, 2'b10 for not found and 2'b11 for protection fault. A fault occurs on a match that is unreadable, or that is a write without write grant. A fault ends the walk without a secondary search.
- R11: Memory addresses are word aligned. Once `mem_valid` is raised, it and the address, write flag, byte enables and write data hold until `mem_ready`. Read data is taken from `mem_rdata` in the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 32 | Effective address |
| req_seg | input | 32 | Selected segment register |
| req_base | input | 32 | Table base and size mask register |
| req_user | input | 1 | 1 = user state, 0 = supervisor |
| req_write | input | 1 | Access is a store |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts / returns data |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done_valid | output | 1 | Result pulse |
| done_code | output | 2 | 01 hit, 10 not found, 11 fault |
| done_pa | output | 32 | Physical address |
| done_rd | output | 1 | Read granted |
| done_wr | output | 1 | Write granted |

## Verification
The assertions assume the request fields matter only in the cycle of acceptance. They also assume that `mem_rdata` carries the word at the presented address whenever `mem_ready` is high. The bench drives read data from its memory model for the address currently shown, and it stalls `mem_ready` on a fixed pattern. It raises `req_valid` only between walks. Hand-built groups cover both hashes, decoy tags that differ only in the secondary bit, duplicate matches, every key and privilege combination, and flags already set.

// File: rtl/hpt_walker.sv
module hpt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_ea,
  input  logic [31:0] req_seg,
  input  logic [31:0] req_base,
  input  logic        req_user,
  input  logic        req_write,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done_valid,
  output logic [1:0]  done_code,
  output logic [31:0] done_pa,
  output logic        done_rd,
  output logic        done_wr
);
  localparam int ENTRIES = 8;
  localparam int IW = $clog2(ENTRIES);
  localparam logic [31:0] REF_FLAG = 32'h0000_0100;
  localparam logic [31:0] CHG_FLAG = 32'h0000_0080;
  localparam logic [1:0] C_HIT = 2'b01, C_MISS = 2'b10, C_FAULT = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CMP, S_UPD, S_DONE} state_t;

  state_t st;
  logic [27:0] ea_q;
  logic [30:0] seg_q;
  logic [31:0] base_q;
  logic user_q, wr_q, sec_q, half_q;
  logic [IW-1:0] idx_q;
  logic [31:0] word_q, w1_q, pa_q;
  logic may_rd_q, may_wr_q, need_r_q, need_c_q;
  logic [1:0] code_q;

  logic unused_bits;
  assign unused_bits = ^{req_ea[31:28], req_seg[31], req_base[15:9], seg_q[28:24]};

  logic [27:0] mix;
  logic [31:0] hash_raw, hash_mask, group, tag;
  logic [2:0]  prot;
  logic        grant_rd, grant_wr;

  assign mix       = seg_q[27:0] ^ {12'd0, ea_q[27:12]};
  assign hash_raw  = {mix[25:0], 6'd0};
  assign hash_mask = {7'd0, base_q[8:0], 16'hFFC0};
  assign group     = {base_q[31:16], 16'd0} | ((sec_q ? ~hash_raw : hash_raw) & hash_mask);
  assign tag       = {1'b1, seg_q[23:0], sec_q, ea_q[27:22]};

  assign prot     = {(user_q ? seg_q[29] : seg_q[30]), word_q[1:0]};
  assign grant_rd = (prot != 3'd4);
  assign grant_wr = (prot == 3'd0) || (prot == 3'd1) || (prot == 3'd2) || (prot == 3'd6);

  assign req_ready  = (st == S_IDLE);
  assign mem_valid  = (st == S_READ) || (st == S_UPD);
  assign mem_we     = (st == S_UPD);
  assign mem_addr   = group | {26'd0, idx_q, (half_q | mem_we), 2'b00};
  assign mem_be     = !mem_we ? 4'b0000 : (need_r_q ? 4'b0010 : 4'b0001);
  assign mem_wdata  = !mem_we ? 32'd0 : (need_r_q ? (w1_q | REF_FLAG) : (w1_q | CHG_FLAG));
  assign done_valid = (st == S_DONE);
  assign done_code  = code_q;
  assign done_pa    = pa_q;
  assign done_rd    = may_rd_q;
  assign done_wr    = may_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ea_q <= '0; seg_q <= '0; base_q <= '0;
      user_q <= 1'b0; wr_q <= 1'b0; sec_q <= 1'b0; half_q <= 1'b0;
      idx_q <= '0; word_q <= '0; w1_q <= '0; pa_q <= '0;
      may_rd_q <= 1'b0; may_wr_q <= 1'b0; need_r_q <= 1'b0; need_c_q <= 1'b0;
      code_q <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q <= req_ea[27:0];
          seg_q <= req_seg[30:0];
          base_q <= req_base;
          user_q <= req_user;
          wr_q <= req_write;
          sec_q <= 1'b0;
          half_q <= 1'b0;
          idx_q <= '0;
          st <= S_READ;
        end
        S_READ: if (mem_ready) begin
          word_q <= mem_rdata;
          st <= S_CMP;
        end
        S_CMP: if (!half_q) begin
          if (word_q == tag) begin
            half_q <= 1'b1;
            st <= S_READ;
          end else if (idx_q == IW'(ENTRIES - 1)) begin
            idx_q <= '0;
            if (!sec_q) begin
              sec_q <= 1'b1;
              st <= S_READ;
            end else begin
              code_q <= C_MISS;
              pa_q <= '0;
              may_rd_q <= 1'b0;
              may_wr_q <= 1'b0;
              st <= S_DONE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            st <= S_READ;
          end
        end else begin
          w1_q <= word_q;
          pa_q <= {word_q[31:12], ea_q[11:0]};
          may_rd_q <= grant_rd;
          may_wr_q <= grant_wr;
          need_r_q <= grant_rd && !word_q[8];
          need_c_q <= wr_q && grant_wr && !word_q[7];
          code_q <= (!grant_rd || (wr_q && !grant_wr)) ? C_FAULT : C_HIT;
          st <= ((grant_rd && !word_q[8]) || (wr_q && grant_wr && !word_q[7])) ? S_UPD : S_DONE;
        end
        S_UPD: if (mem_ready) begin
          if (need_r_q) begin
            need_r_q <= 1'b0;
            w1_q <= w1_q | REF_FLAG;
            if (!need_c_q) st <= S_DONE;
          end else begin
            need_c_q <= 1'b0;
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata));
  p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[31:16] & base_q[31:16]) == base_q[31:16]);
  p_onebyte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> $countones(mem_be) == 1);
  p_refwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_be == 4'b0010 |-> mem_wdata[8] && may_rd_q);
  p_chgwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_be == 4'b0001 |-> mem_wdata[7] && mem_wdata[8] && wr_q && may_wr_q);
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);
  p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_code != 2'b00);
  p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_code == C_MISS |-> !done_rd && !done_wr);
endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_ea = '0, req_seg = '0, req_base = '0;
  logic req_ready, mem_valid, mem_we, done_valid, done_rd, done_wr;
  logic mem_ready = 1'b0;
  logic [3:0] mem_be;
  logic [31:0] mem_addr, mem_wdata, done_pa;
  logic [31:0] mem_rdata = '0;
  logic [1:0] done_code;

  hpt_walker uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_seg(req_seg), .req_base(req_base), .req_user(req_user),
    .req_write(req_write), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_code(done_code), .done_pa(done_pa),
    .done_rd(done_rd), .done_wr(done_wr));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] mem [bit [31:0]];
  logic [31:0] q_addr[$], q_wd[$];
  logic q_we[$];
  logic [3:0] q_be[$];
  logic [1:0] exp_code;
  logic [31:0] exp_pa;
  logic exp_rd, exp_wr, done_seen = 1'b0;
  logic hs_pend = 1'b0, p_we = 1'b0;
  logic [3:0] p_be = '0;
  logic [31:0] p_addr = '0, p_wd = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] grp(input logic [31:0] ea, seg, base, input bit sec);
    logic [31:0] h;
    h = ((seg & 32'h0fff_ffff) ^ ((ea >> 12) & 32'hffff)) << 6;
    if (sec) h = ~h;
    h &= ((base & 32'h1ff) << 16) | 32'hffc0;
    return (base & 32'hffff_0000) | h;
  endfunction

  function automatic logic [31:0] tagw(input logic [31:0] ea, seg, input bit sec);
    return 32'h8000_0000 | ((seg & 32'h0fff_ffff) << 7) | (sec ? 32'h40 : 32'h0) | ((ea & 32'h0fff_ffff) >> 22);
  endfunction

  task automatic put(input logic [31:0] ea, seg, base, input bit sec, input int e, input logic [31:0] w0, w1);
    logic [31:0] a;
    a = grp(ea, seg, base, sec) + 32'(8 * e);
    mem[a] = w0;
    mem[a + 4] = w1;
  endtask

  task automatic expect_acc(input logic [31:0] a, input logic we, input logic [3:0] be, input logic [31:0] wd);
    q_addr.push_back(a); q_we.push_back(we); q_be.push_back(be); q_wd.push_back(wd);
  endtask

  task automatic predict(input logic [31:0] ea, seg, base, input bit user, wr);
    exp_code = 2'b10; exp_pa = 0; exp_rd = 0; exp_wr = 0;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 8; e++) begin
        logic [31:0] a, w1, cur;
        int pp;
        a = grp(ea, seg, base, s[0]) + 32'(8 * e);
        expect_acc(a, 0, 4'b0000, 0);
        if (rd(a) == tagw(ea, seg, s[0])) begin
          expect_acc(a + 4, 0, 4'b0000, 0);
          w1 = rd(a + 4);
          pp = int'(w1 & 3);
          if ((user && seg[29]) || (!user && seg[30])) pp += 4;
          exp_rd = (pp != 4);
          exp_wr = (pp == 0 || pp == 1 || pp == 2 || pp == 6);
          cur = w1;
          if (exp_rd && !cur[8]) begin cur |= 32'h100; expect_acc(a + 4, 1, 4'b0010, cur); end
          if (wr && exp_wr && !cur[7]) begin cur |= 32'h80; expect_acc(a + 4, 1, 4'b0001, cur); end
          exp_code = (!exp_rd || (wr && !exp_wr)) ? 2'b11 : 2'b01;
          exp_pa = (w1 & 32'hffff_f000) | (ea & 32'hfff);
          return;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (hs_pend) begin
      if (q_addr.size() == 0) chk(0, "R4 unexpected access", p_addr, 0);
      else begin
        logic [31:0] ea, ew;
        logic ewe;
        logic [3:0] ebe;
        ea = q_addr.pop_front(); ewe = q_we.pop_front(); ebe = q_be.pop_front(); ew = q_wd.pop_front();
        chk(p_addr == ea, "R2 address", p_addr, ea);
        chk(p_we == ewe, "R4 access kind", 32'(p_we), 32'(ewe));
        if (ewe) begin
          chk(p_be == ebe, "R9 byte enables", 32'(p_be), 32'(ebe));
          chk(p_wd == ew, "R8 write data", p_wd, ew);
        end
      end
      if (p_we) begin
        logic [31:0] o;
        o = rd(p_addr);
        for (int k = 0; k < 4; k++) if (p_be[k]) o[8*k +: 8] = p_wd[8*k +: 8];
        mem[p_addr] = o;
      end
    end
    if (done_valid && rst_n) begin
      done_seen = 1'b1;
      chk(done_code == exp_code, "R10 result code", 32'(done_code), 32'(exp_code));
      chk(done_pa == exp_pa, "R5 physical address", done_pa, exp_pa);
      chk(done_rd == exp_rd, "R7 read grant", 32'(done_rd), 32'(exp_rd));
      chk(done_wr == exp_wr, "R6 write grant", 32'(done_wr), 32'(exp_wr));
      chk(q_addr.size() == 0, "R3 accesses outstanding", 32'(q_addr.size()), 0);
    end
    mem_ready = rst_n && ((cyc % 4) != 2);
    mem_rdata = rd(mem_addr);
    hs_pend = rst_n && mem_valid && mem_ready;
    p_addr = mem_addr; p_we = mem_we; p_be = mem_be; p_wd = mem_wdata;
  end

  task automatic run(input logic [31:0] ea, seg, base, input bit user, wr);
    int n;
    predict(ea, seg, base, user, wr);
    done_seen = 1'b0;
    req_ea = ea; req_seg = seg; req_base = base; req_user = user; req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 32'(req_ready), 0);
    n = 0;
    while (!done_seen && n < 3000) begin @(negedge clk); n++; end
    if (!done_seen) chk(0, "R1 no result", 0, 1);
    @(negedge clk);
    chk(req_ready == 1'b1 && done_valid == 1'b0, "R1 single pulse and idle", {30'd0, req_ready, done_valid}, 32'd2);
  endtask

  localparam logic [31:0] BASE = 32'h0012_0003;

  initial begin
    logic [31:0] ea, seg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !done_valid, "R1 reset state", {29'd0, req_ready, mem_valid, done_valid}, 32'd4);

    // R2 R8: primary entry 0, read, referenced set
    ea = 32'h1234_5678; seg = 32'h0000_0123;
    put(ea, seg, BASE, 0, 0, tagw(ea, seg, 0), 32'h0ABC_D002);
    run(ea, seg, BASE, 0, 0);
    // R9: write at entry 7, both flags set
    mem.delete();
    ea = 32'h2ABC_1004; seg = 32'h0345_6789;
    put(ea, seg, BASE, 0, 7, tagw(ea, seg, 0), 32'h0005_5000);
    run(ea, seg, BASE, 0, 1);
    // R3 R4: decoy with secondary bit in primary group, real match in secondary
    mem.delete();
    ea = 32'h3F00_0ABC; seg = 32'h00F0_0F00;
    put(ea, seg, BASE, 0, 1, tagw(ea, seg, 1), 32'h1111_1002);
    put(ea, seg, BASE, 1, 3, tagw(ea, seg, 1), 32'h7777_7103);
    run(ea, seg, BASE, 0, 0);
    // R10: nothing anywhere
    mem.delete();
    run(32'h0000_0000, 32'h0000_0001, BASE, 0, 0);
    // R6 R10: supervisor key makes code 4, secondary never searched
    mem.delete();
    ea = 32'h4444_4444; seg = 32'h4000_0AAA;
    put(ea, seg, BASE, 0, 2, tagw(ea, seg, 0), 32'h2222_2000);
    put(ea, seg, BASE, 1, 0, tagw(ea, seg, 1), 32'h3333_3002);
    run(ea, seg, BASE, 0, 0);
    // R7: write to read-only code 3 faults but marks referenced
    mem.delete();
    ea = 32'h5000_3FFF; seg = 32'h0000_7777;
    put(ea, seg, BASE, 0, 4, tagw(ea, seg, 0), 32'h4000_0003);
    run(ea, seg, BASE, 0, 1);
    // R6: user with user key, code 6 read/write
    mem.delete();
    ea = 32'h6123_4000; seg = 32'h2000_1234;
    put(ea, seg, BASE, 0, 5, tagw(ea, seg, 0), 32'h5000_0002);
    run(ea, seg, BASE, 1, 1);
    // R7: user key code 5 write faults, flags preset so no writes
    mem.delete();
    ea = 32'h7000_0010; seg = 32'h2000_0042;
    put(ea, seg, BASE, 0, 6, tagw(ea, seg, 0), 32'h6000_0181);
    run(ea, seg, BASE, 1, 1);
    // R4: first of two matches wins
    mem.delete();
    ea = 32'h8765_4321; seg = 32'h0FFF_FFFF;
    put(ea, seg, BASE, 0, 2, tagw(ea, seg, 0), 32'hAAAA_A001);
    put(ea, seg, BASE, 0, 5, tagw(ea, seg, 0), 32'hBBBB_B002);
    run(ea, seg, BASE, 0, 0);
    // R6: supervisor key ignored in user state; changed preset
    mem.delete();
    ea = 32'h9000_5555; seg = 32'h4000_0100;
    put(ea, seg, BASE, 0, 0, tagw(ea, seg, 0), 32'hC000_0082);
    run(ea, seg, BASE, 1, 1);
    // R2: wider size mask, second walk over same group to see prior flag update
    mem.delete();
    ea = 32'hA00F_F000; seg = 32'h0001_FFFF;
    put(ea, seg, 32'h0400_01FF, 1, 7, tagw(ea, seg, 1), 32'hD000_0000);
    run(ea, seg, 32'h0400_01FF, 0, 1);
    run(ea, seg, 32'h0400_01FF, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule